// File: doc/BRIEF.md
# Bit-Serial Elastic Smoothing Buffer

This block takes a serial bit stream that arrives on an irregular write strobe and sends it back out on a regular read strobe. Writes may come in bursts, or with gaps. The block stores the bits in a circular buffer. A divider on the master clock produces the read strobe. The master clock runs at sixteen times the line rate, so the nominal read period is sixteen clocks. All logic runs in the master-clock domain, and the write strobe acts as a clock enable in that domain.

The buffer holds either 128 or 32 bits, chosen by a single select input. Fill is the write pointer minus the read pointer. When fill strays too far from mid-buffer, the divider stretches or shortens its period by one clock. This lets the buffer recover before it overflows or runs dry, and every such slip sets a sticky trip flag. The allowed excursion from mid-buffer is 60 bits in the 128-bit size and 14 bits in the 32-bit size. Those bounds match a tolerated input jitter of 120 and 28 unit intervals peak-to-peak.

A bypass input removes the buffer from the path. The buffer restarts in three cases: on reset, on a change of the size select, and when bypass is released. A restart empties the buffer, clears it, and preloads it to half its size with zero bits. Reading then resumes on the nominal period.

Top module: `elastic_smoother`

## Requirements
- R1: `deep_sel`=1 selects a 128-bit buffer and `deep_sel`=0 selects a 32-bit buffer. A change of `deep_sel`, or a falling `bypass`, restarts the buffer on the next clock edge. After a restart, the first half-size reads deliver 0, and only then do bits written after the restart appear.
- R2: With the fill inside its bounds, `rd_stb` is high for exactly one clock every 16 clocks. `rd_bit` carries the read bit while `rd_stb` is high, and bits leave in the order they were written.
- R3: At a read strobe, if the fill is greater than half size plus the margin, the next read period is 15 clocks. The margin is 60 for the 128-bit size and 14 for the 32-bit size.
- R4: At a read strobe, if the fill is less than half size minus the margin, the next read period is 17 clocks.
- R5: `trip_flag` is set with every read strobe that starts a 15- or 17-clock period. It stays set, through restarts, until `trip_clr` is high at a clock edge. If a slip and `trip_clr` fall on the same edge, the flag ends up set.
- R6: While `bypass`=1, `rd_stb` equals `wr_stb` and `rd_bit` equals `wr_bit` combinationally, and nothing is buffered.
- R7: A write strobe that meets a buffer already holding its full size is dropped, and the fill never exceeds the selected size.
- R8: A read strobe that meets an empty buffer still pulses `rd_stb`, and it delivers `rd_bit`=0.
- R9: Writes that run up to 40 bits ahead of the mean rate in the 128-bit size, or 12 bits ahead in the 32-bit size, are delivered completely and in order, with no slipped period.
- R10: Reset is asynchronous and active-low. Coming out of reset, `rd_stb`, `rd_bit` and `trip_flag` are 0. The buffer starts in the 32-bit size, preloaded to 16 zero bits, and delivers its first read 16 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 16x line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe, one bit per high cycle |
| wr_bit | input | 1 | Write data bit |
| deep_sel | input | 1 | 1: 128-bit buffer, 0: 32-bit buffer |
| bypass | input | 1 | Remove the buffer from the path |
| trip_clr | input | 1 | Clears the trip flag |
| rd_bit | output | 1 | Read data bit |
| rd_stb | output | 1 | Smoothed read strobe |
| trip_flag | output | 1 | Sticky flag, set by a slipped read period |

## Verification
The hardest case to reach is a trip and a clear that land on the same edge. The bench creates it by starving the 32-bit buffer, so that every read period slips, and then holds `trip_clr` high across many periods. Under that stimulus the flag must read 1 on each strobe cycle and 0 between strobes. A full buffer is reached by a back-to-back burst of ones into a freshly preloaded 32-bit buffer. The number of ones that come out shows how many writes were dropped.

// File: rtl/elastic_smoother.sv
module elastic_smoother #(
  parameter int DEEP           = 128,
  parameter int SHALLOW        = 32,
  parameter int NOM_DIV        = 16,
  parameter int DEEP_MARGIN    = 60,
  parameter int SHALLOW_MARGIN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic deep_sel,
  input  logic bypass,
  input  logic trip_clr,
  output logic rd_bit,
  output logic rd_stb,
  output logic trip_flag
);
  localparam int AW = $clog2(DEEP);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(NOM_DIV + 2);
  localparam logic [CW-1:0] LIM_NOM  = CW'(NOM_DIV - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(NOM_DIV - 2);
  localparam logic [CW-1:0] LIM_SLOW = CW'(NOM_DIV);

  logic [DEEP-1:0] mem;
  logic [PW-1:0]   wptr, rptr, fill, depth, center, margin;
  logic [AW-1:0]   amask;
  logic [CW-1:0]   cnt, lim, next_lim;
  logic            deep_q, bypass_q, rd_bit_q, rd_stb_q, trip_q;
  logic            restart, active, rd_evt, wr_ok, rd_ok;

  assign depth   = deep_sel ? PW'(DEEP) : PW'(SHALLOW);
  assign margin  = deep_sel ? PW'(DEEP_MARGIN) : PW'(SHALLOW_MARGIN);
  assign center  = depth >> 1;
  assign amask   = AW'(depth - PW'(1));
  assign fill    = wptr - rptr;
  assign restart = (deep_sel != deep_q) | (bypass_q & ~bypass);
  assign active  = ~bypass & ~restart;
  assign rd_evt  = active & (cnt == lim);
  assign wr_ok   = active & wr_stb & (fill != depth);
  assign rd_ok   = rd_evt & (fill != '0);

  assign next_lim = (fill > center + margin) ? LIM_FAST :
                    (fill + margin < center) ? LIM_SLOW : LIM_NOM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q   <= 1'b0;
      bypass_q <= 1'b0;
      wptr     <= PW'(SHALLOW / 2);
      rptr     <= '0;
      mem      <= '0;
      cnt      <= '0;
      lim      <= LIM_NOM;
      rd_bit_q <= 1'b0;
      rd_stb_q <= 1'b0;
    end else begin
      deep_q   <= deep_sel;
      bypass_q <= bypass;
      if (restart) begin
        wptr     <= center;
        rptr     <= '0;
        mem      <= '0;
        cnt      <= '0;
        lim      <= LIM_NOM;
        rd_bit_q <= 1'b0;
        rd_stb_q <= 1'b0;
      end else if (bypass) begin
        cnt      <= '0;
        rd_stb_q <= 1'b0;
      end else begin
        rd_stb_q <= rd_evt;
        if (rd_evt) begin
          cnt      <= '0;
          lim      <= next_lim;
          rd_bit_q <= rd_ok ? mem[rptr[AW-1:0] & amask] : 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        if (rd_ok) rptr <= rptr + PW'(1);
        if (wr_ok) begin
          mem[wptr[AW-1:0] & amask] <= wr_bit;
          wptr <= wptr + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            trip_q <= 1'b0;
    else if (rd_evt && next_lim != LIM_NOM) trip_q <= 1'b1;
    else if (trip_clr)                     trip_q <= 1'b0;
  end

  assign rd_bit    = bypass ? wr_bit : rd_bit_q;
  assign rd_stb    = bypass ? wr_stb : rd_stb_q;
  assign trip_flag = trip_q;

  assert_restart_preload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> fill == ($past(depth) >> 1));
  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_q |=> !rd_stb_q);
  assert_trip_on_slip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_q && lim != LIM_NOM) |-> trip_q);
  assert_trip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clr |=> (!trip_q || rd_stb_q));
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_stb && fill == depth) |=> $stable(wptr));
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> fill <= depth);
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && fill == '0) |=> (rd_stb_q && !rd_bit_q));
endmodule

// File: tb/test_elastic_smoother.sv
module test_elastic_smoother;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0;
  logic deep_sel = 1'b0, bypass = 1'b0, trip_clr = 1'b0;
  logic rd_bit, rd_stb, trip_flag;
  int vectors = 0, miscompares = 0;
  int cyc = 0, last_cyc = 0;
  bit have_last = 0;
  bit rq[$];
  int gq[$];
  bit sent[$];
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  elastic_smoother i_elastic_smoother (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bit(wr_bit),
    .deep_sel(deep_sel), .bypass(bypass), .trip_clr(trip_clr),
    .rd_bit(rd_bit), .rd_stb(rd_stb), .trip_flag(trip_flag));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!bypass && rd_stb) begin
      rq.push_back(rd_bit);
      if (have_last) gq.push_back(cyc - last_cyc);
      last_cyc = cyc;
      have_last = 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    rq.delete();
    gq.delete();
    have_last = 0;
  endtask

  task automatic put(bit b);
    wr_stb = 1'b1;
    wr_bit = b;
    tick(1);
    wr_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    trip_clr = 1'b1;
    tick(1);
    trip_clr = 1'b0;
  endtask

  task automatic restart_to(bit d);
    bypass = 1'b1;
    deep_sel = d;
    tick(2);
    bypass = 1'b0;
    tick(1);
    clear_mon();
  endtask

  task automatic wait_reads(int n, int limit);
    for (int k = 0; k < limit && rq.size() < n; k++) tick(1);
  endtask

  function automatic int gap_count(int v);
    int c = 0;
    foreach (gq[i]) if (gq[i] == v) c++;
    return c;
  endfunction

  task automatic t_reset();
    tick(3);
    rst_n = 1'b1;
    chk(rd_stb == 1'b0 && rd_bit == 1'b0, "R10 outputs low after reset", rd_stb, 0);
    chk(trip_flag == 1'b0, "R10 trip clear after reset", trip_flag, 0);
    clear_mon();
    tick(20);
    chk(rq.size() == 1, "R10 one read within 20 clocks", rq.size(), 1);
    if (rq.size() > 0) chk(rq[0] == 1'b0, "R10 preloaded bit is zero", rq[0], 0);
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    tick(1);
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 2; b++) begin
        wr_stb = s[0];
        wr_bit = b[0];
        #2;
        chk(rd_stb == wr_stb, "R6 strobe follows write", rd_stb, wr_stb);
        chk(rd_bit == wr_bit, "R6 bit follows write", rd_bit, wr_bit);
        tick(1);
      end
    end
    wr_stb = 1'b0;
    bypass = 1'b0;
    tick(1);
  endtask

  task automatic t_within(bit d, int wins, int burst, int idle, int nzero, int nchk);
    int zbad = 0, dbad = 0, gbad = 0;
    pulse_clr();
    restart_to(d);
    sent.delete();
    for (int w = 0; w < wins; w++) begin
      for (int i = 0; i < burst; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sent.push_back(lfsr[0]);
        put(lfsr[0]);
      end
      tick(idle);
    end
    wait_reads(nzero + nchk, 2000);
    chk(rq.size() >= nzero + nchk, "R9 enough reads", rq.size(), nzero + nchk);
    if (rq.size() >= nzero + nchk) begin
      for (int i = 0; i < nzero; i++) if (rq[i] != 1'b0) zbad++;
      for (int i = 0; i < nchk; i++) if (rq[nzero + i] != sent[i]) dbad++;
      for (int i = 0; i < nzero + nchk - 1; i++) if (gq[i] != 16) gbad++;
    end
    chk(zbad == 0, "R1 preload zeros first", zbad, 0);
    chk(dbad == 0, "R9 data delivered in order", dbad, 0);
    chk(gbad == 0, "R2 every period 16 clocks", gbad, 0);
    chk(trip_flag == 1'b0, "R9 no slip within limits", trip_flag, 0);
  endtask

  task automatic t_overfill();
    int z = 0, ones = 0, after = 0;
    pulse_clr();
    restart_to(1'b0);
    repeat (24) put(1'b1);
    tick(700);
    while (z < rq.size() && rq[z] == 1'b0) z++;
    while (z + ones < rq.size() && rq[z + ones] == 1'b1) ones++;
    if (z + ones < rq.size()) after = rq[z + ones];
    else after = 2;
    chk(z == 16, "R1 sixteen preload zeros", z, 16);
    chk(ones >= 16 && ones <= 18, "R7 writes into full buffer dropped", ones, 17);
    chk(after == 0, "R8 empty read delivers zero", after, 0);
    chk(gap_count(15) > 0, "R3 short period when overfull", gap_count(15), 1);
    chk(trip_flag == 1'b1, "R5 trip set by slip", trip_flag, 1);
  endtask

  task automatic t_underfill();
    int ones = 0;
    pulse_clr();
    restart_to(1'b0);
    tick(16 * 40);
    foreach (rq[i]) if (rq[i]) ones++;
    chk(rq.size() >= 30, "R8 strobe continues when empty", rq.size(), 30);
    chk(ones == 0, "R8 empty reads are zero", ones, 0);
    chk(gq.size() > 0 && gq[0] == 16, "R2 first period nominal", gq.size() > 0 ? gq[0] : -1, 16);
    chk(gq.size() > 0 && gq[gq.size()-1] == 17, "R4 long period when underfull",
        gq.size() > 0 ? gq[gq.size()-1] : -1, 17);
    chk(gap_count(15) == 0, "R4 no short period when underfull", gap_count(15), 0);
    chk(trip_flag == 1'b1, "R4 trip set by long period", trip_flag, 1);
  endtask

  task automatic t_trip();
    int on_bad = 0, off_bad = 0, gbad = 0;
    trip_clr = 1'b1;
    tick(1);
    for (int k = 0; k < 80; k++) begin
      if (rd_stb) begin if (trip_flag != 1'b1) on_bad++; end
      else if (trip_flag != 1'b0) off_bad++;
      tick(1);
    end
    while (!rd_stb) tick(1);
    trip_clr = 1'b0;
    chk(on_bad == 0, "R5 slip wins over same-edge clear", on_bad, 0);
    chk(off_bad == 0, "R5 clear takes effect between strobes", off_bad, 0);
    restart_to(1'b1);
    chk(trip_flag == 1'b1, "R5 flag sticky across restart", trip_flag, 1);
    pulse_clr();
    for (int k = 0; k < 25; k++) begin
      put(1'b1);
      tick(15);
    end
    for (int i = 0; i < gq.size(); i++) if (gq[i] != 16) gbad++;
    chk(trip_flag == 1'b0, "R5 flag cleared and stays clear", trip_flag, 0);
    chk(gbad == 0, "R2 nominal periods at mid fill", gbad, 0);
  endtask

  task automatic t_switch();
    int zbad = 0, obad = 0;
    restart_to(1'b1);
    repeat (40) put(1'b1);
    deep_sel = 1'b0;
    tick(1);
    clear_mon();
    for (int k = 0; k < 30; k++) begin
      put(1'b1);
      tick(15);
    end
    wait_reads(26, 500);
    chk(rq.size() >= 26, "R1 reads after size change", rq.size(), 26);
    if (rq.size() >= 26) begin
      for (int i = 0; i < 16; i++) if (rq[i] != 1'b0) zbad++;
      for (int i = 16; i < 26; i++) if (rq[i] != 1'b1) obad++;
    end
    chk(zbad == 0, "R1 old contents flushed on size change", zbad, 0);
    chk(obad == 0, "R1 new writes follow preload", obad, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_within(1'b1, 5, 40, 600, 64, 120);
    t_within(1'b0, 8, 12, 180, 16, 72);
    t_overfill();
    t_underfill();
    t_trip();
    t_switch();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule